// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device-side register front end of an ATA storage target. It watches the host's two active-low chip selects, the three-bit device address, the active-low read and write strobes, the DMA acknowledge and a 16-bit data bus. The data bus is split into an input half, an output half and an output enable. From these signals it keeps the command-block and control-block registers. Some addresses are shared: a read and a write at the same address reach different registers. Writes that arrive while the device is busy, has a data request open, or is inside a DMA acknowledge are dropped.

It also owns the interrupt request. The request is raised by the backend. It is cleared by a status read, by a command write, or when the host selects this device again. The output enable of the interrupt line follows the device selection and the interrupt-disable bit. A software-reset bit holds the device busy and, when it is released, loads the diagnostic defaults.

On the inside, a plain port gives the backend every task-file value and a one-cycle pulse for each command. It also carries the data-port read and write pulses. In the other direction it accepts Status and Error updates, read data for the data port, and an interrupt-set pulse. Media access, DMA bursts and command execution are left to the backend.

Top module: `ata_tf_regs`

## Requirements
- R1: With cs0_n=0 and cs1_n=1, da selects these registers. Reads: 0 data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 device/head, 7 status. Writes: 0 data, 1 feature, 2 to 6 the same registers as reads, 7 command. Register reads return the value on host_dout[7:0] with host_dout[15:8]=0.
- R2: With cs1_n=0, cs0_n=1 and da=6, a read returns the status value (alternate status) and a write reaches device control. With both chip selects at 0 or both at 1, no register is read (host_doe=0, host_dout=0) and writes change nothing.
- R3: Writes to feature, sector count, sector number, cylinder low/high and device/head are dropped while status bit 7 (BSY) is 1, status bit 3 (DRQ) is 1, or dmack_n=0.
- R4: A device-control write is accepted whenever dmack_n=1, even while BSY=1. Its bit 1 is the interrupt disable and its bit 2 is the software reset.
- R5: The data port moves all 16 bits. It is open only when DRQ=1, BSY=0 and dmack_n=1. A read returns data_rdata and pulses data_rd for one cycle. A write puts the word on data_wdata and pulses data_wr for one cycle. With DRQ=0 a data read returns 0.
- R6: A pending interrupt sets intrq. Reading status clears the pending interrupt; reading alternate status does not.
- R7: A command write with BSY=0, dmack_n=1 and this device selected does four things. It latches the code on cmd_code, pulses cmd_valid for one cycle, sets BSY, and clears a pending interrupt.
- R8: intrq_oe is 1 only when this device is selected and the interrupt-disable bit is 0. intrq is 0 whenever intrq_oe is 0.
- R9: Device/head bit 4 selects the device; this device answers to DEV_ID (default 0). If the other device is selected, host_doe stays 0 and intrq_oe drops. A device/head write that selects this device clears its pending interrupt.
- R10: After hardware reset, and after the software-reset bit returns to 0, status reads 0x40 (DRDY only) and error reads 0x01. While the software-reset bit is 1, status reads 0x80 (BSY only) and backend status updates are ignored.
- R11: While BSY=1, reads of every command-block address return the status value.
- R12: A st_we pulse loads st_val into status, and an er_we pulse loads er_val into error. When a command is accepted in the same cycle, BSY is still forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs0_n | input | 1 | Command-block chip select, active low |
| cs1_n | input | 1 | Control-block chip select, active low |
| da | input | 3 | Device register address |
| dior_n | input | 1 | Host read strobe, active low |
| diow_n | input | 1 | Host write strobe, active low |
| dmack_n | input | 1 | DMA acknowledge, active low |
| host_din | input | 16 | Data from host |
| host_dout | output | 16 | Data to host |
| host_doe | output | 1 | Enable for driving host_dout onto the bus |
| intrq | output | 1 | Interrupt request level |
| intrq_oe | output | 1 | Enable for driving the interrupt line |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_sector | output | 8 | Sector number register |
| tf_cyl_lo | output | 8 | Cylinder low register |
| tf_cyl_hi | output | 8 | Cylinder high register |
| tf_devhead | output | 8 | Device/head register |
| cmd_code | output | 8 | Last accepted command code |
| cmd_valid | output | 1 | One-cycle pulse per accepted command |
| srst_active | output | 1 | Software reset held by host |
| data_wdata | output | 16 | Word written to the data port |
| data_wr | output | 1 | One-cycle data-port write pulse |
| data_rd | output | 1 | One-cycle data-port read pulse |
| data_rdata | input | 16 | Word the backend offers to data-port reads |
| st_we | input | 1 | Status load strobe |
| st_val | input | 8 | New status value |
| er_we | input | 1 | Error load strobe |
| er_val | input | 8 | New error value |
| irq_set | input | 1 | Raise the pending interrupt |

## Verification
Read data is combinational from the registers. The bench therefore samples host_dout and host_doe on the falling edge one cycle after it drives a read strobe low. A write takes effect on the first rising edge after the write strobe goes back high. Read side effects (a cleared interrupt, a data_rd pulse) also land on that edge. The bench checks those results, and the cmd_valid and data_wr pulses, on the falling edge that follows, and checks that cmd_valid has dropped one cycle later. Software reset takes one more cycle after its control write to show BSY. Its release also lands one cycle later, so status is checked with a full read after each control write.

// File: rtl/ata_tf_regs.sv
module ata_tf_regs #(
  parameter int DW     = 16,
  parameter int RW     = 8,
  parameter int AW     = 3,
  parameter bit DEV_ID = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs0_n,
  input  logic          cs1_n,
  input  logic [AW-1:0] da,
  input  logic          dior_n,
  input  logic          diow_n,
  input  logic          dmack_n,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  output logic          intrq,
  output logic          intrq_oe,
  output logic [RW-1:0] tf_feature,
  output logic [RW-1:0] tf_count,
  output logic [RW-1:0] tf_sector,
  output logic [RW-1:0] tf_cyl_lo,
  output logic [RW-1:0] tf_cyl_hi,
  output logic [RW-1:0] tf_devhead,
  output logic [RW-1:0] cmd_code,
  output logic          cmd_valid,
  output logic          srst_active,
  output logic [DW-1:0] data_wdata,
  output logic          data_wr,
  output logic          data_rd,
  input  logic [DW-1:0] data_rdata,
  input  logic          st_we,
  input  logic [RW-1:0] st_val,
  input  logic          er_we,
  input  logic [RW-1:0] er_val,
  input  logic          irq_set
);
  localparam int BSY_B  = 7;
  localparam int DRDY_B = 6;
  localparam int DRQ_B  = 3;
  localparam int NIEN_B = 1;
  localparam int SRST_B = 2;
  localparam int DEV_B  = 4;
  localparam int PAD    = DW - RW;

  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_ERR  = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_SEC  = AW'(3);
  localparam logic [AW-1:0] A_CLO  = AW'(4);
  localparam logic [AW-1:0] A_CHI  = AW'(5);
  localparam logic [AW-1:0] A_DEV  = AW'(6);
  localparam logic [AW-1:0] A_CMD  = AW'(7);
  localparam logic [AW-1:0] A_CTL  = AW'(6);

  localparam logic [RW-1:0] ST_IDLE = RW'(1 << DRDY_B);
  localparam logic [RW-1:0] ST_SRST = RW'(1 << BSY_B);
  localparam logic [RW-1:0] ER_DIAG = RW'(1);

  logic [RW-1:0] feat_q, cnt_q, sec_q, clo_q, chi_q, dev_q, cmd_q, stat_q, err_q;
  logic          nien_q, srst_q, srst_d1;
  logic          rd_q, wr_q, cs0_q, cs1_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          pend_q, cmdv_q, drd_q, dwr_q;

  logic rd_act, wr_act, rd_evt, wr_evt;
  logic busy, drq, sel, cb_q, cq_ctl, tf_ok;
  logic cmd_ok, st_rd_clr, resel_clr, srst_fall;
  logic rd_cb, rd_ctl;
  logic [RW-1:0] rsel;

  assign rd_act    = !dior_n;
  assign wr_act    = !diow_n;
  assign rd_evt    = rd_q && !rd_act;
  assign wr_evt    = wr_q && !wr_act;
  assign busy      = stat_q[BSY_B];
  assign drq       = stat_q[DRQ_B];
  assign sel       = (dev_q[DEV_B] == DEV_ID);
  assign cb_q      = cs0_q && !cs1_q;
  assign cq_ctl    = cs1_q && !cs0_q && (a_q == A_CTL);
  assign tf_ok     = !busy && !drq && dmack_n;
  assign cmd_ok    = wr_evt && cb_q && (a_q == A_CMD) && !busy && dmack_n && sel;
  assign st_rd_clr = rd_evt && cb_q && (a_q == A_CMD) && sel;
  assign resel_clr = wr_evt && cb_q && (a_q == A_DEV) && tf_ok && (wd_q[DEV_B] == DEV_ID);
  assign srst_fall = srst_d1 && !srst_q;

  // host strobe capture: address, selects and data are held while a strobe is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      cs0_q <= 1'b0;
      cs1_q <= 1'b0;
      a_q   <= '0;
      wd_q  <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (rd_act || wr_act) begin
        cs0_q <= !cs0_n;
        cs1_q <= !cs1_n;
        a_q   <= da;
        wd_q  <= host_din;
      end
    end
  end

  // shadow task-file registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0;
      cnt_q  <= '0;
      sec_q  <= '0;
      clo_q  <= '0;
      chi_q  <= '0;
      dev_q  <= '0;
    end else if (wr_evt && cb_q && tf_ok) begin
      case (a_q)
        A_ERR:   feat_q <= wd_q[RW-1:0];
        A_CNT:   cnt_q  <= wd_q[RW-1:0];
        A_SEC:   sec_q  <= wd_q[RW-1:0];
        A_CLO:   clo_q  <= wd_q[RW-1:0];
        A_CHI:   chi_q  <= wd_q[RW-1:0];
        A_DEV:   dev_q  <= wd_q[RW-1:0];
        default: ;
      endcase
    end
  end

  // device control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nien_q  <= 1'b0;
      srst_q  <= 1'b0;
      srst_d1 <= 1'b0;
    end else begin
      srst_d1 <= srst_q;
      if (wr_evt && cq_ctl && dmack_n) begin
        nien_q <= wd_q[NIEN_B];
        srst_q <= wd_q[SRST_B];
      end
    end
  end

  // command and data-port pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      cmdv_q <= 1'b0;
      dwr_q  <= 1'b0;
      drd_q  <= 1'b0;
    end else begin
      cmdv_q <= cmd_ok;
      if (cmd_ok) cmd_q <= wd_q[RW-1:0];
      dwr_q <= wr_evt && cb_q && (a_q == A_DATA) && drq && !busy && dmack_n && sel;
      drd_q <= rd_evt && cb_q && (a_q == A_DATA) && drq && !busy && dmack_n && sel;
    end
  end

  // status and error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= ST_IDLE;
      err_q  <= ER_DIAG;
    end else if (srst_q) begin
      stat_q <= ST_SRST;
    end else if (srst_fall) begin
      stat_q <= ST_IDLE;
      err_q  <= ER_DIAG;
    end else begin
      if (st_we) stat_q <= st_val;
      if (er_we) err_q  <= er_val;
      if (cmd_ok) stat_q[BSY_B] <= 1'b1;
    end
  end

  // pending interrupt: clearing events win over a same-cycle set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                pend_q <= 1'b0;
    else if (srst_q)                           pend_q <= 1'b0;
    else if (st_rd_clr || cmd_ok || resel_clr) pend_q <= 1'b0;
    else if (irq_set)                          pend_q <= 1'b1;
  end

  // host read path
  assign rd_cb  = !cs0_n && cs1_n;
  assign rd_ctl = !cs1_n && cs0_n && (da == A_CTL);

  always_comb begin
    case (da)
      A_ERR:   rsel = err_q;
      A_CNT:   rsel = cnt_q;
      A_SEC:   rsel = sec_q;
      A_CLO:   rsel = clo_q;
      A_CHI:   rsel = chi_q;
      A_DEV:   rsel = dev_q;
      A_CMD:   rsel = stat_q;
      default: rsel = '0;
    endcase
  end

  assign host_doe = rd_act && dmack_n && sel && (rd_cb || rd_ctl);

  always_comb begin
    if (!host_doe)
      host_dout = '0;
    else if (rd_ctl || busy)
      host_dout = {{PAD{1'b0}}, stat_q};
    else if (da == A_DATA)
      host_dout = (drq && dmack_n) ? data_rdata : '0;
    else
      host_dout = {{PAD{1'b0}}, rsel};
  end

  assign intrq_oe    = sel && !nien_q;
  assign intrq       = pend_q && intrq_oe;
  assign tf_feature  = feat_q;
  assign tf_count    = cnt_q;
  assign tf_sector   = sec_q;
  assign tf_cyl_lo   = clo_q;
  assign tf_cyl_hi   = chi_q;
  assign tf_devhead  = dev_q;
  assign cmd_code    = cmd_q;
  assign cmd_valid   = cmdv_q;
  assign srst_active = srst_q;
  assign data_wdata  = wd_q;
  assign data_wr     = dwr_q;
  assign data_rd     = drd_q;
endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk #(
  parameter int DW = 16,
  parameter int RW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs0_n,
  input logic          cs1_n,
  input logic [AW-1:0] da,
  input logic          host_doe,
  input logic [DW-1:0] host_dout,
  input logic          cmd_valid,
  input logic [RW-1:0] stat_q,
  input logic [RW-1:0] cnt_q,
  input logic          pend_q,
  input logic          srst_q,
  input logic          st_rd_clr,
  input logic          wr_evt,
  input logic          cb_q,
  input logic [AW-1:0] a_q
);
  // R7
  cmd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> stat_q[7]);

  // R7
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R6
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_clr |=> !pend_q);

  // R2
  dual_select_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n && !cs1_n) |-> !host_doe);

  // R3
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && cb_q && (a_q == AW'(2)) && stat_q[7]) |=> $stable(cnt_q));

  // R10
  srst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && $past(srst_q)) |-> stat_q[7]);

  // R1
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_doe && !(!cs0_n && cs1_n && (da == AW'(0)))) |-> (host_dout[DW-1:RW] == '0));
endmodule

bind ata_tf_regs ata_tf_chk #(.DW(DW), .RW(RW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da),
  .host_doe(host_doe), .host_dout(host_dout), .cmd_valid(cmd_valid),
  .stat_q(stat_q), .cnt_q(cnt_q), .pend_q(pend_q), .srst_q(srst_q),
  .st_rd_clr(st_rd_clr), .wr_evt(wr_evt), .cb_q(cb_q), .a_q(a_q)
);

// File: tb/sim_ata_tf_regs.sv
module sim_ata_tf_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] CB = 2'b10, CT = 2'b01, NO = 2'b11, BO = 2'b00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs0_n = 1'b1, cs1_n = 1'b1;
  logic [2:0] da = '0;
  logic dior_n = 1'b1, diow_n = 1'b1, dmack_n = 1'b1;
  logic [15:0] host_din = '0, data_rdata = '0;
  logic st_we = 1'b0, er_we = 1'b0, irq_set = 1'b0;
  logic [7:0] st_val = '0, er_val = '0;
  logic [15:0] host_dout, data_wdata;
  logic host_doe, intrq, intrq_oe, cmd_valid, srst_active, data_wr, data_rd;
  logic [7:0] tf_feature, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi, tf_devhead, cmd_code;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_tf_regs u0 (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da),
    .dior_n(dior_n), .diow_n(diow_n), .dmack_n(dmack_n), .host_din(host_din),
    .host_dout(host_dout), .host_doe(host_doe), .intrq(intrq), .intrq_oe(intrq_oe),
    .tf_feature(tf_feature), .tf_count(tf_count), .tf_sector(tf_sector),
    .tf_cyl_lo(tf_cyl_lo), .tf_cyl_hi(tf_cyl_hi), .tf_devhead(tf_devhead),
    .cmd_code(cmd_code), .cmd_valid(cmd_valid), .srst_active(srst_active),
    .data_wdata(data_wdata), .data_wr(data_wr), .data_rd(data_rd),
    .data_rdata(data_rdata), .st_we(st_we), .st_val(st_val),
    .er_we(er_we), .er_val(er_val), .irq_set(irq_set)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  cs;
    logic [2:0]  a;
    logic [15:0] val;
    logic [15:0] exp;
    logic        oe;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, CB, 3'd2, 16'h005A, 16'h0000, 1'b0},
    '{1'b1, CB, 3'd3, 16'h0011, 16'h0000, 1'b0},
    '{1'b1, CB, 3'd4, 16'h00C3, 16'h0000, 1'b0},
    '{1'b1, CB, 3'd5, 16'h003C, 16'h0000, 1'b0},
    '{1'b1, CB, 3'd6, 16'h00A0, 16'h0000, 1'b0},
    '{1'b0, CB, 3'd2, 16'h0000, 16'h005A, 1'b1},
    '{1'b0, CB, 3'd3, 16'h0000, 16'h0011, 1'b1},
    '{1'b0, CB, 3'd4, 16'h0000, 16'h00C3, 1'b1},
    '{1'b0, CB, 3'd5, 16'h0000, 16'h003C, 1'b1},
    '{1'b0, CB, 3'd6, 16'h0000, 16'h00A0, 1'b1},
    '{1'b0, CB, 3'd1, 16'h0000, 16'h0001, 1'b1},
    '{1'b0, CB, 3'd7, 16'h0000, 16'h0040, 1'b1},
    '{1'b0, CT, 3'd6, 16'h0000, 16'h0040, 1'b1},
    '{1'b0, NO, 3'd7, 16'h0000, 16'h0000, 1'b0},
    '{1'b0, BO, 3'd7, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, BO, 3'd2, 16'h00FF, 16'h0000, 1'b0},
    '{1'b0, CB, 3'd2, 16'h0000, 16'h005A, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] cs, input logic [2:0] a, input logic [15:0] v);
    {cs1_n, cs0_n} = cs;
    da = a;
    host_din = v;
    diow_n = 1'b0;
    @(negedge clk);
    diow_n = 1'b1;
    @(negedge clk);
    {cs1_n, cs0_n} = NO;
  endtask

  task automatic hrd(input logic [1:0] cs, input logic [2:0] a,
                     output logic [15:0] d, output logic oe);
    {cs1_n, cs0_n} = cs;
    da = a;
    dior_n = 1'b0;
    @(negedge clk);
    d = host_dout;
    oe = host_doe;
    dior_n = 1'b1;
    @(negedge clk);
    {cs1_n, cs0_n} = NO;
  endtask

  task automatic pulse_irq();
    irq_set = 1'b1;
    @(negedge clk);
    irq_set = 1'b0;
  endtask

  task automatic set_status(input logic [7:0] v);
    st_val = v;
    st_we = 1'b1;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 reset cmd_valid", {15'd0, cmd_valid}, 16'h0000);
    chk("R8 reset intrq_oe", {15'd0, intrq_oe}, 16'h0001);
    chk("R6 reset intrq", {15'd0, intrq}, 16'h0000);
    hrd(CB, 3'd7, d, oe);
    chk("R10 reset status", d, 16'h0040);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        hwr(VEC[i].cs, VEC[i].a, VEC[i].val);
      end else begin
        hrd(VEC[i].cs, VEC[i].a, d, oe);
        chk((VEC[i].cs == CB) ? "R1 table dout" : "R2 table dout", d, VEC[i].exp);
        chk((VEC[i].cs == CB) ? "R1 table doe" : "R2 table doe", {15'd0, oe}, {15'd0, VEC[i].oe});
      end
    end

    hwr(CB, 3'd1, 16'h0077);
    chk("R1 feature write", {8'd0, tf_feature}, 16'h0077);

    // R6 status read clears, alternate status does not
    pulse_irq();
    chk("R6 intrq raised", {15'd0, intrq}, 16'h0001);
    hrd(CT, 3'd6, d, oe);
    chk("R6 alt read keeps intrq", {15'd0, intrq}, 16'h0001);
    hrd(CB, 3'd7, d, oe);
    chk("R6 status read clears intrq", {15'd0, intrq}, 16'h0000);

    // R8 interrupt disable
    pulse_irq();
    hwr(CT, 3'd6, 16'h0002);
    chk("R8 nien oe", {15'd0, intrq_oe}, 16'h0000);
    chk("R8 nien intrq", {15'd0, intrq}, 16'h0000);
    hwr(CT, 3'd6, 16'h0000);
    chk("R8 enable restores intrq", {15'd0, intrq}, 16'h0001);
    hrd(CB, 3'd7, d, oe);

    // R9 device selection
    pulse_irq();
    hwr(CB, 3'd6, 16'h00B0);
    chk("R9 other device oe", {15'd0, intrq_oe}, 16'h0000);
    hrd(CB, 3'd7, d, oe);
    chk("R9 unselected no drive", {15'd0, oe}, 16'h0000);
    hwr(CB, 3'd6, 16'h00A0);
    chk("R9 reselect oe", {15'd0, intrq_oe}, 16'h0001);
    chk("R9 reselect clears intrq", {15'd0, intrq}, 16'h0000);

    // R7 command write
    pulse_irq();
    hwr(CB, 3'd7, 16'h00EC);
    chk("R7 cmd_valid pulse", {15'd0, cmd_valid}, 16'h0001);
    chk("R7 cmd_code", {8'd0, cmd_code}, 16'h00EC);
    chk("R7 cmd clears intrq", {15'd0, intrq}, 16'h0000);
    @(negedge clk);
    chk("R7 cmd_valid one cycle", {15'd0, cmd_valid}, 16'h0000);
    hrd(CB, 3'd7, d, oe);
    chk("R7 busy set", d, 16'h00C0);

    // R11 reads under busy
    hrd(CB, 3'd2, d, oe);
    chk("R11 count reads status", d, 16'h00C0);
    hrd(CB, 3'd0, d, oe);
    chk("R11 data reads status", d, 16'h00C0);

    // R3 write dropped under busy, R4 control accepted under busy
    hwr(CB, 3'd2, 16'h0099);
    hwr(CT, 3'd6, 16'h0002);
    chk("R4 control under busy", {15'd0, intrq_oe}, 16'h0000);
    hwr(CT, 3'd6, 16'h0000);

    // R12 backend status load
    set_status(8'h58);
    hrd(CB, 3'd7, d, oe);
    chk("R12 status load", d, 16'h0058);
    hrd(CB, 3'd2, d, oe);
    chk("R3 busy write dropped", d, 16'h005A);
    hwr(CB, 3'd3, 16'h0022);
    hrd(CB, 3'd3, d, oe);
    chk("R3 drq write dropped", d, 16'h0011);

    // R5 data port
    data_rdata = 16'hBEEF;
    hrd(CB, 3'd0, d, oe);
    chk("R5 data read 16 bit", d, 16'hBEEF);
    chk("R5 data_rd pulse", {15'd0, data_rd}, 16'h0001);
    hwr(CB, 3'd0, 16'h1234);
    chk("R5 data_wr pulse", {15'd0, data_wr}, 16'h0001);
    chk("R5 data_wdata", data_wdata, 16'h1234);
    set_status(8'h40);
    hrd(CB, 3'd0, d, oe);
    chk("R5 data closed without drq", d, 16'h0000);

    // R3 and R4 with DMA acknowledge asserted
    dmack_n = 1'b0;
    hwr(CB, 3'd4, 16'h0055);
    hwr(CT, 3'd6, 16'h0002);
    dmack_n = 1'b1;
    hrd(CB, 3'd4, d, oe);
    chk("R3 dmack write dropped", d, 16'h00C3);
    chk("R4 dmack control dropped", {15'd0, intrq_oe}, 16'h0001);

    // R12 error load, R10 software reset
    er_val = 8'h04;
    er_we = 1'b1;
    @(negedge clk);
    er_we = 1'b0;
    hrd(CB, 3'd1, d, oe);
    chk("R12 error load", d, 16'h0004);
    hwr(CT, 3'd6, 16'h0004);
    chk("R10 srst active", {15'd0, srst_active}, 16'h0001);
    hrd(CB, 3'd7, d, oe);
    chk("R10 srst status", d, 16'h0080);
    set_status(8'h41);
    hrd(CB, 3'd7, d, oe);
    chk("R10 backend ignored in srst", d, 16'h0080);
    hwr(CT, 3'd6, 16'h0000);
    hrd(CB, 3'd7, d, oe);
    chk("R10 status after srst", d, 16'h0040);
    hrd(CB, 3'd1, d, oe);
    chk("R10 error after srst", d, 16'h0001);

    finish_run();
  end
endmodule